// File: doc/BRIEF.md
# Beam-Search Add-Compare-Select Unit

This block carries out one step of a beam-search decoder for a rateless hash-based code. It keeps a small set of surviving paths, each with an accumulated path cost. Every survivor can be extended by any value of the next short message segment. For each received symbol the block takes one branch metric per extension. Each metric is a squared constellation distance computed upstream. The block adds that metric to the parent's cost and keeps only the cheapest extensions as the new survivors.

A step is offered as a vector of `BEAM << SEG_BITS` metrics, with a valid/ready handshake. Once it is accepted, the block ranks the candidates one per cycle against all the others at once. A candidate whose rank is below the beam width is written straight into the survivor slot with that number, so the survivors always come out in ascending cost order. A one-cycle done pulse marks the end of the ranking. Each survivor is reported with its cost and a mark. The mark says which parent slot it came from and which segment value it added, for the traceback logic downstream. A packet-start input returns the beam to a single zero-cost root path.

Top module: `beam_acs`

## Requirements
- R1: After reset, and in the cycle after `start_packet` is high while no step is in progress, slot 0 holds cost 0 and mark 0. Slots 1 to 3 hold cost 0xFFFFF (unused) and mark 0.
- R2: `in_ready` is high when no step is in progress and `start_packet` is low. A step is accepted on a clock edge with `in_valid` and `in_ready` both high, and `in_ready` is low from the next cycle until `done`.
- R3: Candidate c (0..31) takes metric c from bits `[16c +: 16]` of `in_metrics`. Its parent is survivor slot c/8 and its segment value is c mod 8. Its cost is the parent's cost plus the metric.
- R4: A candidate cost that would pass 0xFFFFF is held at 0xFFFFF and never wraps. Children of unused slots therefore never beat a real path.
- R5: The 4 candidates with the lowest cost become the new survivors. Slot s holds the candidate whose rank is s, so the slots are in ascending cost order.
- R6: A candidate's rank is the number of candidates with a strictly lower cost plus the number of equal-cost candidates with a lower index. Equal costs therefore resolve toward the lower index.
- R7: Each survivor's 5-bit mark is {parent slot[1:0], segment[2:0]}, which equals the candidate index c.
- R8: `done` is high for exactly one cycle, 32 clock edges after the accepting edge. At that point all four survivor slots hold the new result.
- R9: `start_packet` and `in_valid` have no effect while a step is in progress.
- R10: Each accepted step uses the survivor costs left by the previous step as parent costs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_packet | input | 1 | Return the beam to the single root path |
| in_valid | input | 1 | Metric vector is valid |
| in_ready | output | 1 | Block can accept a step |
| in_metrics | input | 512 | 32 branch metrics of 16 bits, candidate c at bits [16c +: 16] |
| done | output | 1 | One-cycle pulse: survivors updated |
| out_cost | output | 80 | Survivor costs, slot s at bits [20s +: 20] |
| out_mark | output | 20 | Survivor marks, slot s at bits [5s +: 5] |

## Verification
After a metric vector is offered, `in_ready` falls in the cycle after the accepting edge. The bench samples it at the falling edge that follows. `done` must still be low after the 31st edge following acceptance and high after the 32nd. Survivor costs and marks are compared with a bench-side ranking model in that same cycle, and `done` must be low again one cycle later. A `start_packet` pulse given while idle is checked one edge later. Disturbing pulses sent mid-step are followed by the normal count, so the result checked at the 32nd edge shows that they were ignored.

// File: rtl/beam_acs_pkg.sv
package beam_acs_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RANK = 1'b1
   } acs_state_t;

endpackage

// File: rtl/acs_expand.sv
module acs_expand #(
   parameter int BEAM     = 4,
   parameter int SEG_BITS = 3,
   parameter int COST_W   = 20,
   parameter int METRIC_W = 16,
   localparam int N       = BEAM << SEG_BITS
) (
   input  logic [BEAM*COST_W-1:0] surv_flat,
   input  logic [N*METRIC_W-1:0]  metrics,
   output logic [N*COST_W-1:0]    cand_flat
);

   generate
      for (genvar c = 0; c < N; c++) begin : g_cand
         localparam int P = c >> SEG_BITS;
         logic [COST_W-1:0] par;
         logic [COST_W:0]   sum;
         assign par = surv_flat[P*COST_W +: COST_W];
         assign sum = {1'b0, par} + (COST_W+1)'(metrics[c*METRIC_W +: METRIC_W]);
         assign cand_flat[c*COST_W +: COST_W] = sum[COST_W] ? {COST_W{1'b1}} : sum[COST_W-1:0];

         always_comb begin
            AST_NO_WRAP: assert (cand_flat[c*COST_W +: COST_W] >= par); // R4
         end
      end
   endgenerate

endmodule

// File: rtl/acs_rank.sv
module acs_rank #(
   parameter int N       = 32,
   parameter int COST_W  = 20,
   localparam int IDX_W  = $clog2(N),
   localparam int RANK_W = $clog2(N) + 1
) (
   input  logic [N*COST_W-1:0] cand_flat,
   input  logic [IDX_W-1:0]    sel,
   output logic [RANK_W-1:0]   rank_o
);

   logic [COST_W-1:0] own;
   logic [N-1:0]      beats;

   assign own = cand_flat[sel*COST_W +: COST_W];

   generate
      for (genvar j = 0; j < N; j++) begin : g_cmp
         logic [COST_W-1:0] other;
         assign other    = cand_flat[j*COST_W +: COST_W];
         assign beats[j] = (other < own) || ((other == own) && (IDX_W'(j) < sel));
      end
   endgenerate

   assign rank_o = RANK_W'($countones(beats));

endmodule

// File: rtl/beam_acs.sv
module beam_acs #(
   parameter int BEAM     = 4,
   parameter int SEG_BITS = 3,
   parameter int COST_W   = 20,
   parameter int METRIC_W = 16,
   localparam int N       = BEAM << SEG_BITS,
   localparam int IDX_W   = $clog2(N),
   localparam int RANK_W  = $clog2(N) + 1,
   localparam int PAR_W   = $clog2(BEAM),
   localparam int MARK_W  = IDX_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_packet,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [N*METRIC_W-1:0]    in_metrics,
   output logic                     done,
   output logic [BEAM*COST_W-1:0]   out_cost,
   output logic [BEAM*MARK_W-1:0]   out_mark
);
   import beam_acs_pkg::*;

   generate
      if (BEAM < 2 || (BEAM & (BEAM - 1)) != 0) begin : g_bad_beam
         $error("BEAM must be a power of two, at least 2");
      end
      if (METRIC_W > COST_W) begin : g_bad_width
         $error("METRIC_W must not exceed COST_W");
      end
   endgenerate

   acs_state_t        state;
   logic [COST_W-1:0] surv_cost [BEAM];
   logic [MARK_W-1:0] surv_mark [BEAM];
   logic [BEAM*COST_W-1:0] surv_flat;
   logic [N*COST_W-1:0]    cand_now;
   logic [N*COST_W-1:0]    cand_q;
   logic [IDX_W-1:0]       idx;
   logic [RANK_W-1:0]      rank;
   logic                   accept;

   assign in_ready = (state == ST_IDLE) && !start_packet;
   assign accept   = in_valid && in_ready;

   generate
      for (genvar b = 0; b < BEAM; b++) begin : g_flat
         assign surv_flat[b*COST_W +: COST_W] = surv_cost[b];
         assign out_cost[b*COST_W +: COST_W]  = surv_cost[b];
         assign out_mark[b*MARK_W +: MARK_W]  = surv_mark[b];
      end
   endgenerate

   acs_expand #(
      .BEAM(BEAM), .SEG_BITS(SEG_BITS), .COST_W(COST_W), .METRIC_W(METRIC_W)
   ) u_expand (
      .surv_flat(surv_flat),
      .metrics  (in_metrics),
      .cand_flat(cand_now)
   );

   acs_rank #(
      .N(N), .COST_W(COST_W)
   ) u_rank (
      .cand_flat(cand_q),
      .sel      (idx),
      .rank_o   (rank)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         done   <= 1'b0;
         idx    <= '0;
         cand_q <= '0;
         for (int b = 0; b < BEAM; b++) begin
            surv_cost[b] <= (b == 0) ? '0 : '1;
            surv_mark[b] <= '0;
         end
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_packet) begin
                  for (int b = 0; b < BEAM; b++) begin
                     surv_cost[b] <= (b == 0) ? '0 : '1;
                     surv_mark[b] <= '0;
                  end
               end else if (accept) begin
                  cand_q <= cand_now;
                  idx    <= '0;
                  state  <= ST_RANK;
               end
            end
            ST_RANK: begin
               if (rank < RANK_W'(BEAM)) begin
                  surv_cost[rank[PAR_W-1:0]] <= cand_q[idx*COST_W +: COST_W];
                  surv_mark[rank[PAR_W-1:0]] <= idx;
               end
               if (idx == IDX_W'(N - 1)) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_ROOT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start_packet && state == ST_IDLE) |=> (surv_cost[0] == '0 && surv_cost[1] == '1)); // R1
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !in_ready); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   generate
      for (genvar b = 0; b + 1 < BEAM; b++) begin : g_order
         AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (surv_cost[b] <= surv_cost[b+1])); // R5
      end
   endgenerate

endmodule

// File: tb/beam_acs_test.sv
`timescale 1ns/1ps
module beam_acs_test;
   localparam int MAXC = 20'hFFFFF;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_packet = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [511:0] in_metrics = '0;
   logic         done;
   logic [79:0]  out_cost;
   logic [19:0]  out_mark;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   int unsigned par_m [4];
   int unsigned exp_cost [4];
   int unsigned exp_mark [4];
   logic [15:0] met [32];

   always #4 clk = ~clk;

   beam_acs uut (
      .clk(clk), .rst_n(rst_n), .start_packet(start_packet),
      .in_valid(in_valid), .in_ready(in_ready), .in_metrics(in_metrics),
      .done(done), .out_cost(out_cost), .out_mark(out_mark)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_step();
      int unsigned cand [32];
      for (int c = 0; c < 32; c++) begin
         cand[c] = par_m[c >> 3] + met[c];
         if (cand[c] > MAXC) cand[c] = MAXC;
      end
      for (int c = 0; c < 32; c++) begin
         int r = 0;
         for (int j = 0; j < 32; j++)
            if (cand[j] < cand[c] || (cand[j] == cand[c] && j < c)) r++;
         if (r < 4) begin
            exp_cost[r] = cand[c];
            exp_mark[r] = c;
         end
      end
      for (int b = 0; b < 4; b++) par_m[b] = exp_cost[b];
   endtask

   task automatic check_slots(input string req);
      for (int b = 0; b < 4; b++) begin
         chk(out_cost[b*20 +: 20] == exp_cost[b][19:0], req, int'(out_cost[b*20 +: 20]), int'(exp_cost[b]));
         chk(out_mark[b*5 +: 5] == exp_mark[b][4:0], {req, " mark R7"}, int'(out_mark[b*5 +: 5]), int'(exp_mark[b]));
      end
   endtask

   task automatic set_root();
      for (int b = 0; b < 4; b++) begin
         par_m[b] = (b == 0) ? 0 : MAXC;
         exp_cost[b] = par_m[b];
         exp_mark[b] = 0;
      end
   endtask

   task automatic run_step(input string req, input bit disturb);
      for (int c = 0; c < 32; c++) in_metrics[c*16 +: 16] = met[c];
      @(negedge clk);
      chk(in_ready == 1'b1, "R2 ready idle", int'(in_ready), 1);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk(in_ready == 1'b0, "R2 busy after accept", int'(in_ready), 0);
      model_step();
      if (disturb) begin
         repeat (10) @(posedge clk);
         @(negedge clk);
         start_packet = 1'b1;
         in_valid = 1'b1;
         in_metrics = '0;
         @(posedge clk);
         @(negedge clk);
         start_packet = 1'b0;
         in_valid = 1'b0;
         repeat (20) @(posedge clk);
      end else begin
         repeat (31) @(posedge clk);
      end
      @(negedge clk);
      chk(done == 1'b0, "R8 done not early", int'(done), 0);
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b1, "R8 done at edge 32", int'(done), 1);
      check_slots(req);
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
      check_slots({req, " hold"});
   endtask

   task automatic t_reset();
      set_root();
      @(negedge clk);
      check_slots("R1 reset");
   endtask

   task automatic t_root_wrap();
      // R4: root children are large, children of unused slots would wrap to small
      for (int c = 0; c < 32; c++) met[c] = (c < 8) ? 16'(16'hFFF0 - c * 100) : 16'd5;
      run_step("R4 R3 saturating root step", 1'b0);
   endtask

   task automatic t_full_step();
      // R10 R5 R3: all parents valid, mixed metrics
      for (int c = 0; c < 32; c++) met[c] = 16'(((c * 53) ^ (c << 4)) % 997);
      run_step("R10 R5 full step", 1'b0);
   endtask

   task automatic t_ties();
      for (int c = 0; c < 32; c++) met[c] = 16'd100;
      run_step("R6 equal metrics", 1'b0);
   endtask

   task automatic t_busy();
      for (int c = 0; c < 32; c++) met[c] = 16'((31 - c) * 7 + (c & 3));
      run_step("R9 ignore while busy", 1'b1);
   endtask

   task automatic t_restart();
      @(negedge clk);
      start_packet = 1'b1;
      #1;
      chk(in_ready == 1'b0, "R2 not ready during start", int'(in_ready), 0);
      @(posedge clk);
      @(negedge clk);
      start_packet = 1'b0;
      set_root();
      check_slots("R1 start_packet");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_root_wrap();
      t_full_step();
      t_ties();
      t_busy();
      t_restart();
      t_root_wrap();
      t_full_step();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule